// File: doc/BRIEF.md
# Two-Phase Nonoverlapping Clock Generator

This block turns one fast oscillator clock into two nonoverlapping processor clock phases. A modulo-nine slot counter runs on the oscillator. A small region state machine walks through three regions of the frame: phase 1, phase 2 and the dead band. Registered decode logic then drives phase 1, phase 2, a separate logic-level copy of phase 2, and three one-cycle lead markers. The lead markers warn downstream logic one oscillator cycle before each region boundary. The slot number is exported so companion logic can align to any point of the processor cycle. A buffered copy of the oscillator is also provided.

One processor cycle is nine oscillator periods. Phase 1 is high in slots 0 and 1. Phase 2 is high in slots 2 through 6, and it rises on the same edge on which phase 1 falls. Slots 7 and 8 are a dead band in which both phases are low. The region states are `RG_PH1`, `RG_PH2` and `RG_DEAD`, with these transitions:

- `RG_PH1` to `RG_PH2` when slot 1 ends.
- `RG_PH2` to `RG_DEAD` when slot 6 ends.
- `RG_DEAD` to `RG_PH1` when slot 8 ends and the counter wraps.
- Any state to `RG_DEAD` at slot 7 when reset is applied.

The power-on reset is active high and asynchronous.

Top module: `twophase_clkgen`

## Requirements
- R1: `slot_o` advances by one on every oscillator rising edge outside reset and wraps from 8 to 0, giving a nine-cycle frame.
- R2: `ph1_o` is high exactly while `slot_o` is 0 or 1, which is 2 cycles per frame.
- R3: `ph2_o` is high exactly while `slot_o` is 2 to 6, which is 5 cycles per frame. It rises on the edge where `ph1_o` falls, so its leading edge comes 2 cycles after that of `ph1_o`.
- R4: In slots 7 and 8 both phases are low, so `ph1_o` rises 2 cycles after `ph2_o` falls.
- R5: `ph1_o` and `ph2_o` are never high in the same cycle.
- R6: `ph2_lvl_o` equals `ph2_o` in every cycle.
- R7: While `por_rst` is high, `slot_o` is 7 and every phase and marker output is low. After release, `ph1_o` rises on the second oscillator rising edge.
- R8: `ph1_lead_o` is high only in slot 8, `ph2_lead_o` only in slot 1, and `dead_lead_o` only in slot 6. Each marker lasts one cycle and comes just before phase 1 rises, phase 2 rises and phase 2 falls, in that order.
- R9: `osc_out_o` follows `osc_clk` with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_rst | input | 1 | Power-on reset, active high, asynchronous |
| ph1_o | output | 1 | Processor clock phase 1 |
| ph2_o | output | 1 | Processor clock phase 2 |
| ph2_lvl_o | output | 1 | Logic-level copy of phase 2 |
| osc_out_o | output | 1 | Buffered oscillator |
| slot_o | output | 4 | Current slot, 0 to 8 |
| ph1_lead_o | output | 1 | High in the cycle before phase 1 rises |
| ph2_lead_o | output | 1 | High in the cycle before phase 2 rises |
| dead_lead_o | output | 1 | High in the cycle before phase 2 falls |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a frame, in each region and at each slot. The counter and the region state machine must then both return to the dead band together, and no phase may glitch high. The stimulus sweeps short reset pulses of one and two cycles across all nine slot positions. Between pulses it lets full frames run, and it compares every output each cycle against a behavioural slot model. It also measures the spacing between edges directly.

// File: rtl/twophase_pkg.sv
package twophase_pkg;
    typedef enum logic [1:0] {
        RG_PH1  = 2'd0,
        RG_PH2  = 2'd1,
        RG_DEAD = 2'd2
    } region_e;
endpackage

// File: rtl/tp_slot_counter.sv
module tp_slot_counter
    import twophase_pkg::*;
#(
    parameter int SLOTS  = 9,
    parameter int P1_LEN = 2,
    parameter int P2_LEN = 5,
    parameter int CW     = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output region_e       region_d
);
    localparam logic [CW-1:0] LAST_C   = CW'(SLOTS - 1);
    localparam logic [CW-1:0] P1_END_C = CW'(P1_LEN - 1);
    localparam logic [CW-1:0] P2_END_C = CW'(P1_LEN + P2_LEN - 1);
    localparam logic [CW-1:0] RST_C    = CW'(P1_LEN + P2_LEN);

    region_e region_q;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q    <= RST_C;
            region_q <= RG_DEAD;
        end else begin
            cnt_q    <= cnt_d;
            region_q <= region_d;
        end
    end

    // next slot and region
    always_comb begin
        cnt_d    = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
        region_d = region_q;
        unique case (region_q)
            RG_PH1:  if (cnt_q == P1_END_C) region_d = RG_PH2;
            RG_PH2:  if (cnt_q == P2_END_C) region_d = RG_DEAD;
            RG_DEAD: if (cnt_q == LAST_C)   region_d = RG_PH1;
            default: region_d = RG_DEAD;
        endcase
    end
endmodule

// File: rtl/tp_phase_decode.sv
module tp_phase_decode
    import twophase_pkg::*;
#(
    parameter int SLOTS  = 9,
    parameter int P1_LEN = 2,
    parameter int P2_LEN = 5,
    parameter int CW     = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_d,
    input  region_e       region_d,
    output logic          ph1_q,
    output logic          ph2_q,
    output logic          ph2_lvl_q,
    output logic          ph1_lead_q,
    output logic          ph2_lead_q,
    output logic          dead_lead_q
);
    localparam logic [CW-1:0] LAST_C   = CW'(SLOTS - 1);
    localparam logic [CW-1:0] P1_END_C = CW'(P1_LEN - 1);
    localparam logic [CW-1:0] P2_END_C = CW'(P1_LEN + P2_LEN - 1);

    // outputs registered from the next state, so they line up with the slot
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ph1_q       <= 1'b0;
            ph2_q       <= 1'b0;
            ph2_lvl_q   <= 1'b0;
            ph1_lead_q  <= 1'b0;
            ph2_lead_q  <= 1'b0;
            dead_lead_q <= 1'b0;
        end else begin
            ph1_q       <= (region_d == RG_PH1);
            ph2_q       <= (region_d == RG_PH2);
            ph2_lvl_q   <= (region_d == RG_PH2);
            ph1_lead_q  <= (cnt_d == LAST_C);
            ph2_lead_q  <= (cnt_d == P1_END_C);
            dead_lead_q <= (cnt_d == P2_END_C);
        end
    end
endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen
    import twophase_pkg::*;
#(
    parameter int SLOTS  = 9,
    parameter int P1_LEN = 2,
    parameter int P2_LEN = 5,
    parameter int CW     = $clog2(SLOTS)
) (
    input  logic          osc_clk,
    input  logic          por_rst,
    output logic          ph1_o,
    output logic          ph2_o,
    output logic          ph2_lvl_o,
    output logic          osc_out_o,
    output logic [CW-1:0] slot_o,
    output logic          ph1_lead_o,
    output logic          ph2_lead_o,
    output logic          dead_lead_o
);
    logic [CW-1:0] cnt_d;
    region_e       region_d;

    tp_slot_counter #(
        .SLOTS(SLOTS), .P1_LEN(P1_LEN), .P2_LEN(P2_LEN), .CW(CW)
    ) cnt_i (
        .clk      (osc_clk),
        .rst      (por_rst),
        .cnt_q    (slot_o),
        .cnt_d    (cnt_d),
        .region_d (region_d)
    );

    tp_phase_decode #(
        .SLOTS(SLOTS), .P1_LEN(P1_LEN), .P2_LEN(P2_LEN), .CW(CW)
    ) dec_i (
        .clk         (osc_clk),
        .rst         (por_rst),
        .cnt_d       (cnt_d),
        .region_d    (region_d),
        .ph1_q       (ph1_o),
        .ph2_q       (ph2_o),
        .ph2_lvl_q   (ph2_lvl_o),
        .ph1_lead_q  (ph1_lead_o),
        .ph2_lead_q  (ph2_lead_o),
        .dead_lead_q (dead_lead_o)
    );

    assign osc_out_o = osc_clk;
endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk #(
    parameter int SLOTS  = 9,
    parameter int P1_LEN = 2,
    parameter int P2_LEN = 5,
    parameter int CW     = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst,
    input logic          ph1,
    input logic          ph2,
    input logic          ph2_lvl,
    input logic [CW-1:0] slot,
    input logic          ph1_lead,
    input logic          ph2_lead,
    input logic          dead_lead
);
    localparam logic [CW-1:0] LAST_C = CW'(SLOTS - 1);
    localparam logic [CW-1:0] RST_C  = CW'(P1_LEN + P2_LEN);

    // R1
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST_C) |=> (slot == '0));
    // R1
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST_C) |=> (slot == $past(slot) + 1'b1));
    // R3
    ph2_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ph1) |-> ph2);
    // R4
    dead_band_chk: assert property (@(posedge clk) disable iff (rst)
        (slot >= RST_C) |-> (!ph1 && !ph2));
    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(ph1 && ph2));
    // R6
    lvl_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ph2_lvl == ph2);
    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |-> (slot == RST_C && !ph1 && !ph2 && !ph1_lead && !ph2_lead && !dead_lead));
    // R8
    ph1_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ph1_lead |=> $rose(ph1));
    // R8
    ph2_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ph2_lead |=> $rose(ph2));
    // R8
    dead_lead_chk: assert property (@(posedge clk) disable iff (rst)
        dead_lead |=> $fell(ph2));
    // R8
    marker_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph1_lead, ph2_lead, dead_lead}));
endmodule

bind twophase_clkgen twophase_clkgen_chk #(
    .SLOTS(SLOTS), .P1_LEN(P1_LEN), .P2_LEN(P2_LEN), .CW(CW)
) chk_i (
    .clk       (osc_clk),
    .rst       (por_rst),
    .ph1       (ph1_o),
    .ph2       (ph2_o),
    .ph2_lvl   (ph2_lvl_o),
    .slot      (slot_o),
    .ph1_lead  (ph1_lead_o),
    .ph2_lead  (ph2_lead_o),
    .dead_lead (dead_lead_o)
);

// File: tb/twophase_clkgen_tb_top.sv
`timescale 1ns/1ps
module twophase_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       ph1, ph2, ph2_lvl, osc_out, ph1_lead, ph2_lead, dead_lead;
    logic [3:0] slot;

    int n_cmp = 0;
    int n_bad = 0;
    int ref_slot = 7;
    int cyc = 0;
    int ph1_rise_cyc = -100;
    int ph2_fall_cyc = -100;
    int rel_cyc = -100;
    bit seen_ph2_fall = 0;
    bit await_first = 0;
    logic ph1_prev = 0, ph2_prev = 0;

    always #2 clk = ~clk;

    twophase_clkgen dut_i (
        .osc_clk(clk), .por_rst(rst), .ph1_o(ph1), .ph2_o(ph2),
        .ph2_lvl_o(ph2_lvl), .osc_out_o(osc_out), .slot_o(slot),
        .ph1_lead_o(ph1_lead), .ph2_lead_o(ph2_lead), .dead_lead_o(dead_lead)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural slot model
    always @(posedge clk) begin
        if (rst) ref_slot = 7;
        else     ref_slot = (ref_slot + 1) % 9;
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            chk("R7 slot in reset", int'(slot), 7);
            chk("R7 phases in reset", int'({ph1, ph2, ph2_lvl}), 0);
            chk("R7 markers in reset", int'({ph1_lead, ph2_lead, dead_lead}), 0);
            seen_ph2_fall = 0;
        end else begin
            chk("R1 slot", int'(slot), ref_slot);
            chk("R2 ph1", int'(ph1), int'(ref_slot < 2));
            chk("R3 ph2", int'(ph2), int'(ref_slot >= 2 && ref_slot <= 6));
            if (ref_slot >= 7) chk("R4 dead band", int'(ph1 | ph2), 0);
            chk("R5 overlap", int'(ph1 & ph2), 0);
            chk("R6 lvl copy", int'(ph2_lvl), int'(ph2));
            chk("R8 ph1_lead", int'(ph1_lead), int'(ref_slot == 8));
            chk("R8 ph2_lead", int'(ph2_lead), int'(ref_slot == 1));
            chk("R8 dead_lead", int'(dead_lead), int'(ref_slot == 6));
            if (ph1 && !ph1_prev) begin
                if (seen_ph2_fall) chk("R4 ph2 fall to ph1 rise", cyc - ph2_fall_cyc, 2);
                if (await_first) begin
                    chk("R7 first ph1 after release", cyc - rel_cyc, 2);
                    await_first = 0;
                end
                ph1_rise_cyc = cyc;
            end
            if (ph2 && !ph2_prev) chk("R3 ph1 rise to ph2 rise", cyc - ph1_rise_cyc, 2);
            if (!ph2 && ph2_prev) begin
                ph2_fall_cyc = cyc;
                seen_ph2_fall = 1;
            end
        end
        ph1_prev = ph1;
        ph2_prev = ph2;
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_rst();
        @(negedge clk);
        #1 rst = 1'b0;
        rel_cyc = cyc;
        await_first = 1;
    endtask

    initial begin
        #1 rst = 1'b1;
        run(3);
        release_rst();
        run(40);
        // R9 buffered oscillator, checked away from both edges
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 chk("R9 osc high", int'(osc_out), 1);
            @(negedge clk); #1 chk("R9 osc low", int'(osc_out), 0);
        end
        // reset pulses swept across every slot, one and two cycles long (R7)
        for (int k = 0; k < 9; k++) begin
            for (int w = 1; w <= 2; w++) begin
                run(k + 9);
                #1 rst = 1'b1;
                run(w - 1);
                release_rst();
            end
        end
        run(30);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule